// File: doc/BRIEF.md
# Lockable Outer Bank Configurator

This block holds the outer banking configuration of a multi-game cartridge. The CPU writes to one address window (0x5000 to 0x5FFF). A 2-bit write index picks which of four configuration registers takes each write, and the index steps to the next register after every accepted write. Together the four registers set the outer program and pattern base values, the two bank masks and a personality-select bit. The masks are written in inverted form.

The last register of the sequence carries a lock bit. Once it is set, the configuration is frozen: later writes change neither the registers nor the index, until the reset input is asserted. The banking logic that uses these outputs is outside this block. Each output takes its new value on the clock edge that accepts the write.

Top module: `outer_bank_cfg`

## Requirements
- R1: After reset the write index is 0. Each accepted write goes to the register chosen by the index, and the index then increments modulo 4 (0, 1, 2, 3, 0, ...).
- R2: A write at index 0 replaces outer_chr[7:0] with the written byte. All other outer_chr bits are unchanged.
- R3: A write at index 1 replaces outer_prg[7:0] with the written byte. outer_prg[8] is unchanged.
- R4: A write at index 2 sets three things. chr_mask becomes 0xFF shifted right by the bitwise inverse of data[3:0]; a shift of 8 or more gives 0, so chr_mask has data[3:0]-7 low ones when data[3:0] is 7 or more, and is zero otherwise. outer_chr[11:8] becomes data[7:4]. alt_mode becomes data[7].
- R5: A write at index 3 sets prg_mask to the inverse of data[5:0], sets both outer_prg[8] and outer_chr[12] to data[6], and sets locked to data[7].
- R6: While locked is 1, writes change no output and do not advance the index. Only reset clears locked.
- R7: While rst_n is low at a clock edge, the block returns to its defaults: index 0, prg_mask 0x3F, chr_mask 0xFF, outer_prg 0, outer_chr 0, alt_mode 0, locked 0. Reset takes priority over a write in the same cycle.
- R8: A write is accepted only when wr_en is 1 and wr_addr[15:12] is 0x5. Any other address, including 0x8000 and above, changes no output and leaves the index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset that restores the defaults |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| prg_mask | output | 6 | Program bank mask |
| outer_prg | output | 9 | Outer program base |
| chr_mask | output | 8 | Pattern bank mask |
| outer_chr | output | 13 | Outer pattern base |
| alt_mode | output | 1 | Personality select |
| locked | output | 1 | Configuration frozen |

## Verification
Two functions can fall in the same cycle: the write at index 3 that carries the lock bit and the configuration update it makes. That one write must update prg_mask, both top base bits and locked together, and the very next write must be rejected. A second collision is reset asserted while a write is presented to the window. The bench drives both collisions and then checks every output against a model that it keeps itself. For the reset case it also checks that the next write lands at index 0.

// File: rtl/obc_pkg.sv
package obc_pkg;
  localparam int IDX_W      = 2;
  localparam int NUM_REGS   = 1 << IDX_W;
  localparam int PMASK_W    = 6;
  localparam int OPRG_W     = 9;
  localparam int CMASK_W    = 8;
  localparam int OCHR_W     = 13;
  localparam int DATA_W     = 8;

  // Pattern mask: all-ones shifted right by the inverted low nibble
  function automatic logic [CMASK_W-1:0] f_chr_mask(input logic [3:0] nib);
    logic [3:0] sh;
    sh = ~nib;
    return {CMASK_W{1'b1}} >> sh;
  endfunction

  // Program mask: stored as the inverse of the written field
  function automatic logic [PMASK_W-1:0] f_prg_mask(input logic [PMASK_W-1:0] fld);
    return ~fld;
  endfunction
endpackage

// File: rtl/obc_decode.sv
module obc_decode #(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] REGION_MASK = 16'hF000,
  parameter logic [15:0] REGION_BASE = 16'h5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              locked,
  output logic              in_region,
  output logic              accept
);
  assign in_region = (wr_addr & REGION_MASK[ADDR_W-1:0]) == REGION_BASE[ADDR_W-1:0];
  assign accept    = rst_n && wr_en && in_region && !locked;

  assert_accept_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !accept);
  assert_region_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (wr_addr[ADDR_W-1:ADDR_W-4] == 4'h5));
endmodule

// File: rtl/obc_index.sv
module obc_index
  import obc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  output logic [IDX_W-1:0]    idx,
  output logic [NUM_REGS-1:0] sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (accept) idx <= idx + 1'b1;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = accept && (idx == IDX_W'(g));
  end

  assert_idx_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> idx == IDX_W'($past(idx) + 1));
  assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(idx));
  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/obc_regs.sv
module obc_regs
  import obc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] sel,
  input  logic [DATA_W-1:0]   data,
  output logic [PMASK_W-1:0]  prg_mask,
  output logic [OPRG_W-1:0]   outer_prg,
  output logic [CMASK_W-1:0]  chr_mask,
  output logic [OCHR_W-1:0]   outer_chr,
  output logic                alt_mode,
  output logic                locked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_mask  <= {PMASK_W{1'b1}};
      outer_prg <= '0;
      chr_mask  <= {CMASK_W{1'b1}};
      outer_chr <= '0;
      alt_mode  <= 1'b0;
      locked    <= 1'b0;
    end else begin
      if (sel[0]) outer_chr[7:0] <= data;
      if (sel[1]) outer_prg[7:0] <= data;
      if (sel[2]) begin
        chr_mask        <= f_chr_mask(data[3:0]);
        outer_chr[11:8] <= data[7:4];
        alt_mode        <= data[7];
      end
      if (sel[3]) begin
        prg_mask      <= f_prg_mask(data[PMASK_W-1:0]);
        outer_prg[8]  <= data[6];
        outer_chr[12] <= data[6];
        locked        <= data[7];
      end
    end
  end

  assert_chr_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel[0] |=> outer_chr[7:0] == $past(data));
  assert_prg_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel[1] |=> outer_prg[7:0] == $past(data));
  assert_cmask_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_mask & (chr_mask + 1'b1)) == '0);
  assert_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel[2] |=> alt_mode == $past(data[7]));
  assert_lock_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel[3] |=> locked == $past(data[7]));
  assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/outer_bank_cfg.sv
module outer_bank_cfg
  import obc_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] REGION_MASK = 16'hF000,
  parameter logic [15:0] REGION_BASE = 16'h5000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [PMASK_W-1:0]  prg_mask,
  output logic [OPRG_W-1:0]   outer_prg,
  output logic [CMASK_W-1:0]  chr_mask,
  output logic [OCHR_W-1:0]   outer_chr,
  output logic                alt_mode,
  output logic                locked
);
  logic                in_region;
  logic                accept;
  logic [IDX_W-1:0]    idx;
  logic [NUM_REGS-1:0] sel;

  obc_decode #(.ADDR_W(ADDR_W), .REGION_MASK(REGION_MASK), .REGION_BASE(REGION_BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .locked(locked), .in_region(in_region), .accept(accept)
  );

  obc_index u_idx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .idx(idx), .sel(sel)
  );

  obc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .data(wr_data),
    .prg_mask(prg_mask), .outer_prg(outer_prg), .chr_mask(chr_mask),
    .outer_chr(outer_chr), .alt_mode(alt_mode), .locked(locked)
  );

  assert_ignored_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_region) |=> ($stable(prg_mask) && $stable(outer_prg) && $stable(chr_mask)
                               && $stable(outer_chr) && $stable(alt_mode) && $stable(locked)));
  assert_locked_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en) |=> ($stable(prg_mask) && $stable(outer_prg) && $stable(chr_mask)
                           && $stable(outer_chr) && $stable(alt_mode)));
  assert_top_bits_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outer_prg[8] == outer_chr[12]);
endmodule

// File: tb/tb_outer_bank_cfg.sv
module tb_outer_bank_cfg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [5:0]  prg_mask;
  logic [8:0]  outer_prg;
  logic [7:0]  chr_mask;
  logic [12:0] outer_chr;
  logic        alt_mode, locked;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  int          m_idx;
  logic [5:0]  m_pm;
  logic [8:0]  m_op;
  logic [7:0]  m_cm;
  logic [12:0] m_oc;
  logic        m_mode, m_lock;

  always #2.5 clk = ~clk;

  outer_bank_cfg dut (.*);

  // vector: {en, addr, data}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 16'h5000, 8'h3C}, {1'b1, 16'h8000, 8'hFF}, {1'b1, 16'h5123, 8'h81},
    {1'b1, 16'h5FFF, 8'h3F}, {1'b0, 16'h5000, 8'h77}, {1'b1, 16'h5800, 8'h15},
    {1'b1, 16'h5001, 8'hA5}, {1'b1, 16'h4FFF, 8'h00}, {1'b1, 16'h5002, 8'h7E},
    {1'b1, 16'h5003, 8'h9A}, {1'b1, 16'hE001, 8'h12}, {1'b1, 16'h5004, 8'hC0},
    {1'b1, 16'h5005, 8'h11}, {1'b1, 16'h5006, 8'h22}
  };

  function automatic logic [7:0] exp_cmask(input logic [3:0] n);
    logic [7:0] m = '0;
    int ones = (n >= 7) ? int'(n) - 7 : 0;
    for (int i = 0; i < 8; i++) if (i < ones) m[i] = 1'b1;
    return m;
  endfunction

  task automatic model_reset();
    m_idx = 0; m_pm = 6'h3F; m_op = '0; m_cm = 8'hFF; m_oc = '0; m_mode = 0; m_lock = 0;
  endtask

  task automatic model_write(input logic en, input logic [15:0] a, input logic [7:0] d,
                             output string tag);
    if (!en || a[15:12] != 4'h5) begin tag = "R8"; return; end
    if (m_lock) begin tag = "R6"; return; end
    case (m_idx)
      0: begin m_oc[7:0] = d; tag = "R1/R2"; end
      1: begin m_op[7:0] = d; tag = "R1/R3"; end
      2: begin m_cm = exp_cmask(d[3:0]); m_oc[11:8] = d[7:4]; m_mode = d[7]; tag = "R1/R4"; end
      default: begin m_pm = ~d[5:0]; m_op[8] = d[6]; m_oc[12] = d[6]; m_lock = d[7]; tag = "R1/R5"; end
    endcase
    m_idx = (m_idx + 1) % 4;
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (prg_mask !== m_pm || outer_prg !== m_op || chr_mask !== m_cm ||
        outer_chr !== m_oc || alt_mode !== m_mode || locked !== m_lock) begin
      n_bad++;
      $display("FAIL %s: got pm=%h op=%h cm=%h oc=%h mode=%b lk=%b exp pm=%h op=%h cm=%h oc=%h mode=%b lk=%b",
               tag, prg_mask, outer_prg, chr_mask, outer_chr, alt_mode, locked,
               m_pm, m_op, m_cm, m_oc, m_mode, m_lock);
    end
  endtask

  task automatic do_write(input logic en, input logic [15:0] a, input logic [7:0] d);
    string tag;
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(en, a, d, tag);
    compare(tag);
  endtask

  task automatic do_reset_with_write();
    @(negedge clk);
    rst_n = 0; wr_en = 1; wr_addr = 16'h5000; wr_data = 8'hFF;
    @(negedge clk);
    rst_n = 1; wr_en = 0;
    model_reset();
    compare("R7");
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R7");  // defaults after reset

    for (int i = 0; i < NV; i++) do_write(VEC[i][24], VEC[i][23:8], VEC[i][7:0]);

    // reset clears lock and wins over a coincident write
    do_reset_with_write();
    // next write must land at index 0 (R1, R7)
    do_write(1, 16'h5000, 8'h00);
    do_write(1, 16'h5000, 8'h00);
    do_write(1, 16'h5000, 8'h07);   // R4 boundary: shift 8 gives mask 0
    do_write(1, 16'h5000, 8'h3F);   // R5: prg_mask 0, no lock
    do_write(1, 16'h5000, 8'hFF);   // R1 wrap to index 0
    do_write(1, 16'h5000, 8'h55);
    do_write(1, 16'h5000, 8'h08);   // R4: one-bit mask
    do_write(1, 16'h5000, 8'hBF);   // R5: lock with bit6 clear
    do_write(1, 16'h5000, 8'hEE);   // R6: rejected
    do_write(1, 16'h9000, 8'h01);   // R8: out of window
    do_reset_with_write();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule